// File: doc/BRIEF.md
# Link Acknowledge / Negative-Acknowledge Frame Generator

This block builds the short link-layer control frames that a receiver returns to its peer. A positive acknowledge frame tells the peer which frame sequence number was last received intact and hands back flow-control credit for one traffic class. A negative acknowledge frame tells the peer that a received frame failed its CRC check and must be resent. Each frame closes with a CRC-16 symbol, so the peer can check it. Credit bookkeeping and the retransmission decision belong to neighbouring blocks. This block only formats and sends the frames.

Requests arrive as single-cycle pulses carrying their fields. They are held in pending slots, so a request that lands while a frame is being sent is not lost. Repeated requests of the same kind merge, and the newest fields are kept. Frames leave as a stream of 17-bit symbols on a valid/ready handshake. Bit 16 is set on a control symbol and clear on a data symbol.

The state machine has six states:
- `ST_IDLE`: nothing to send.
- `ST_NAK_HDR` and `ST_NAK_CRC`: the two symbols of a negative acknowledge frame.
- `ST_ACK_HDR`, `ST_ACK_BODY` and `ST_ACK_CRC`: the three symbols of a positive acknowledge frame.

The transitions are named as follows:
- Start-nak: from `ST_IDLE` or from a CRC state whose symbol is accepted, to `ST_NAK_HDR` when a nak is pending.
- Start-ack: the same starting points, to `ST_ACK_HDR` when only an acknowledge is pending.
- Advance: HDR to BODY to CRC, each step taken on an accepted symbol.
- Finish: a CRC state whose symbol is accepted, to `ST_IDLE` when nothing is pending.
- Hold: any state stays where it is while its symbol is not accepted.

Top module: `ctl_frame_gen`

## Requirements
- R1: While reset is asserted and after its release with no request, `out_valid` is low, and no frame is sent until a request arrives.
- R2: An acknowledge frame's first symbol is the control symbol `{1, ESC_CODE[7:0], 4'h2, tc zero-extended to 3 bits, creq}`. The traffic class sits in bits 3:1 and the credit-request flag in bit 0.
- R3: An acknowledge frame's second symbol is the data symbol `{0, seq[4:0], 3'b000, credit[7:0]}`.
- R4: A negative acknowledge frame's first symbol is the control symbol `{1, ESC_CODE[7:0], 4'h5, 3'b000, creq}`.
- R5: The last symbol of each frame is the data symbol `{0, crc[15:0]}`. The CRC uses the polynomial x^16+x^12+x^5+1 with an all-ones preset and no final inversion. It is taken over all 17 bits, MSB first, of every earlier symbol of the same frame. An acknowledge frame therefore has three symbols and a negative acknowledge frame has two.
- R6: When both kinds of request are pending at a frame boundary, the negative acknowledge frame is sent first.
- R7: A frame in progress is never interrupted. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_sym` hold their values.
- R8: Requests of the same kind that arrive before their frame starts merge into one frame carrying the newest fields.
- R9: A request that arrives while a frame is being sent is kept. The frame for that request begins in the cycle right after the last symbol of the current frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_req | input | 1 | Acknowledge request pulse |
| ack_seq | input | SEQ_W | Last good frame sequence number |
| ack_credit | input | CRED_W | Credit value returned |
| ack_tc | input | TC_W | Traffic class |
| ack_creq | input | 1 | Credit-request flag for the acknowledge |
| nak_req | input | 1 | Negative acknowledge request pulse |
| nak_creq | input | 1 | Credit-request flag for the nak |
| out_valid | output | 1 | Symbol valid |
| out_sym | output | 17 | Symbol; bit 16 set marks a control symbol |
| out_ready | input | 1 | Downstream accepts the symbol |

## Verification
Two events can fall in the same cycle, and the bench provokes both.

The first is a frame boundary, where the last CRC symbol is accepted, coinciding with new requests of both kinds. The bench fires an acknowledge and a nak together, and also fires fresh requests exactly as a frame closes. The second is an accepted symbol coinciding with a request that overwrites the pending fields. The bench repeats acknowledge requests during a stalled frame.

A behavioural model holds the pending slots and a queue of expected symbols, with the CRC computed independently. Every cycle, the bench compares the model's valid flag and front symbol with the design's outputs. A wrong priority, a lost request, or a merged request that keeps stale fields therefore shows up as a miscompare.

// File: rtl/ctl_frame_pkg.sv
package ctl_frame_pkg;
    localparam int SYM_W   = 17;
    localparam int PAY_W   = 16;
    localparam logic [3:0] ACK_ID = 4'h2;
    localparam logic [3:0] NAK_ID = 4'h5;
    localparam logic [15:0] CRC_PRESET = 16'hFFFF;
    localparam logic [15:0] CRC_POLY   = 16'h1021;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK_HDR,
        ST_ACK_BODY,
        ST_ACK_CRC,
        ST_NAK_HDR,
        ST_NAK_CRC
    } frm_state_t;
endpackage

// File: rtl/ctl_crc16.sv
// One CRC-16 step over a whole 17-bit symbol, MSB first.
module ctl_crc16
    import ctl_frame_pkg::*;
(
    input  logic [15:0]      crc_in,
    input  logic [SYM_W-1:0] sym,
    output logic [15:0]      crc_out
);
    always_comb begin
        logic [15:0] c;
        logic        fb;
        c = crc_in;
        for (int i = SYM_W - 1; i >= 0; i--) begin
            fb = c[15] ^ sym[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        crc_out = c;
    end
endmodule

// File: rtl/ctl_req_latch.sv
// Pending slots for both request kinds; a new request overwrites stored fields.
module ctl_req_latch #(
    parameter int SEQ_W  = 5,
    parameter int CRED_W = 8,
    parameter int TC_W   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_req,
    input  logic [SEQ_W-1:0]  ack_seq,
    input  logic [CRED_W-1:0] ack_credit,
    input  logic [TC_W-1:0]   ack_tc,
    input  logic              ack_creq,
    input  logic              nak_req,
    input  logic              nak_creq,
    input  logic              take_ack,
    input  logic              take_nak,
    output logic              ack_pend,
    output logic              nak_pend,
    output logic [SEQ_W-1:0]  st_seq,
    output logic [CRED_W-1:0] st_credit,
    output logic [TC_W-1:0]   st_tc,
    output logic              st_ack_creq,
    output logic              st_nak_creq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_pend    <= 1'b0;
            nak_pend    <= 1'b0;
            st_seq      <= '0;
            st_credit   <= '0;
            st_tc       <= '0;
            st_ack_creq <= 1'b0;
            st_nak_creq <= 1'b0;
        end else begin
            // A new request wins over a same-cycle take of the old one.
            if (ack_req) begin
                ack_pend    <= 1'b1;
                st_seq      <= ack_seq;
                st_credit   <= ack_credit;
                st_tc       <= ack_tc;
                st_ack_creq <= ack_creq;
            end else if (take_ack) begin
                ack_pend <= 1'b0;
            end
            if (nak_req) begin
                nak_pend    <= 1'b1;
                st_nak_creq <= nak_creq;
            end else if (take_nak) begin
                nak_pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ctl_frame_gen.sv
module ctl_frame_gen
    import ctl_frame_pkg::*;
#(
    parameter int          SEQ_W    = 5,
    parameter int          CRED_W   = 8,
    parameter int          TC_W     = 1,
    parameter logic [7:0]  ESC_CODE = 8'hA6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_req,
    input  logic [SEQ_W-1:0]  ack_seq,
    input  logic [CRED_W-1:0] ack_credit,
    input  logic [TC_W-1:0]   ack_tc,
    input  logic              ack_creq,
    input  logic              nak_req,
    input  logic              nak_creq,
    output logic              out_valid,
    output logic [SYM_W-1:0]  out_sym,
    input  logic              out_ready
);
    localparam int GAP_W = PAY_W - SEQ_W - CRED_W;

    frm_state_t state_q, state_d;
    logic ack_pend, nak_pend, st_ack_creq, st_nak_creq;
    logic [SEQ_W-1:0]  st_seq, cur_seq;
    logic [CRED_W-1:0] st_credit, cur_credit;
    logic [TC_W-1:0]   st_tc, cur_tc;
    logic              cur_creq;
    logic [15:0]       crc_q, crc_next;
    logic              fire, at_boundary, take_ack, take_nak;

    ctl_req_latch #(.SEQ_W(SEQ_W), .CRED_W(CRED_W), .TC_W(TC_W)) u_latch (
        .clk(clk), .rst_n(rst_n),
        .ack_req(ack_req), .ack_seq(ack_seq), .ack_credit(ack_credit),
        .ack_tc(ack_tc), .ack_creq(ack_creq),
        .nak_req(nak_req), .nak_creq(nak_creq),
        .take_ack(take_ack), .take_nak(take_nak),
        .ack_pend(ack_pend), .nak_pend(nak_pend),
        .st_seq(st_seq), .st_credit(st_credit), .st_tc(st_tc),
        .st_ack_creq(st_ack_creq), .st_nak_creq(st_nak_creq)
    );

    ctl_crc16 u_crc (.crc_in(crc_q), .sym(out_sym), .crc_out(crc_next));

    assign fire        = out_valid && out_ready;
    assign at_boundary = (state_q == ST_IDLE) ||
                         (fire && (state_q == ST_ACK_CRC || state_q == ST_NAK_CRC));
    assign take_nak    = at_boundary && nak_pend;
    assign take_ack    = at_boundary && !nak_pend && ack_pend;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (at_boundary) begin
            if (nak_pend)      state_d = ST_NAK_HDR;
            else if (ack_pend) state_d = ST_ACK_HDR;
            else               state_d = ST_IDLE;
        end else if (fire) begin
            unique case (state_q)
                ST_ACK_HDR:  state_d = ST_ACK_BODY;
                ST_ACK_BODY: state_d = ST_ACK_CRC;
                ST_NAK_HDR:  state_d = ST_NAK_CRC;
                default:     state_d = state_q;
            endcase
        end
    end

    // State register, frame snapshot and running CRC
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            crc_q      <= CRC_PRESET;
            cur_seq    <= '0;
            cur_credit <= '0;
            cur_tc     <= '0;
            cur_creq   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (at_boundary) begin
                crc_q <= CRC_PRESET;
            end else if (fire && (state_q == ST_ACK_HDR || state_q == ST_ACK_BODY ||
                                  state_q == ST_NAK_HDR)) begin
                crc_q <= crc_next;
            end
            if (take_nak) begin
                cur_creq <= st_nak_creq;
            end else if (take_ack) begin
                cur_seq    <= st_seq;
                cur_credit <= st_credit;
                cur_tc     <= st_tc;
                cur_creq   <= st_ack_creq;
            end
        end
    end

    // Output symbol per state
    always_comb begin
        logic [2:0]       tc3;
        logic [PAY_W-1:0] body;
        tc3 = '0;
        tc3[TC_W-1:0] = cur_tc;
        body = '0;
        body[PAY_W-1 -: SEQ_W] = cur_seq;
        body[CRED_W-1:0]       = cur_credit;
        out_valid = 1'b1;
        out_sym   = '0;
        unique case (state_q)
            ST_IDLE:     out_valid = 1'b0;
            ST_ACK_HDR:  out_sym = {1'b1, ESC_CODE, ACK_ID, tc3, cur_creq};
            ST_ACK_BODY: out_sym = {1'b0, body};
            ST_NAK_HDR:  out_sym = {1'b1, ESC_CODE, NAK_ID, 3'b000, cur_creq};
            ST_ACK_CRC,
            ST_NAK_CRC:  out_sym = {1'b0, crc_q};
            default:     out_valid = 1'b0;
        endcase
    end

    // Assertions
    assert_sym_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sym)));

    assert_hdr_followed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_sym[16]) |=> (out_valid && !out_sym[16]));

    assert_nak_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK_HDR && $past(state_q) != ST_ACK_HDR) |-> !$past(nak_pend));

    assert_ack_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_pend && !nak_pend && fire && (state_q == ST_ACK_CRC || state_q == ST_NAK_CRC))
        |=> (state_q == ST_ACK_HDR));

    assert_idle_no_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !ack_pend && !nak_pend) |-> !out_valid);

    if (GAP_W < 0 || TC_W > 3) begin : g_bad_param
        initial $error("ctl_frame_gen: field widths do not fit a 16-bit payload");
    end
endmodule

// File: tb/ctl_frame_gen_tb.sv
module ctl_frame_gen_tb;
    localparam logic [7:0] ESC = 8'hA6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ack_req = 0, ack_creq = 0, nak_req = 0, nak_creq = 0, out_ready = 0;
    logic [4:0] ack_seq = '0;
    logic [7:0] ack_credit = '0;
    logic [0:0] ack_tc = '0;
    logic out_valid;
    logic [16:0] out_sym;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    string phase_tag = "R1";

    always #2 clk = ~clk;

    ctl_frame_gen u_dut (
        .clk(clk), .rst_n(rst_n),
        .ack_req(ack_req), .ack_seq(ack_seq), .ack_credit(ack_credit),
        .ack_tc(ack_tc), .ack_creq(ack_creq),
        .nak_req(nak_req), .nak_creq(nak_creq),
        .out_valid(out_valid), .out_sym(out_sym), .out_ready(out_ready)
    );

    // Behavioural reference model
    logic [16:0] exp_q[$];
    string       tag_q[$];
    bit          m_ack_p, m_nak_p, m_ack_creq, m_nak_creq;
    bit [4:0]    m_seq;
    bit [7:0]    m_cred;
    bit          m_tc;

    function automatic logic [15:0] crc_over(input logic [16:0] s0, input logic [16:0] s1, input int n);
        logic [15:0] c = 16'hFFFF;
        logic [16:0] s;
        for (int k = 0; k < n; k++) begin
            s = (k == 0) ? s0 : s1;
            for (int b = 16; b >= 0; b--) begin
                if (c[15] ^ s[b]) c = (c << 1) ^ 16'h1021;
                else              c = c << 1;
            end
        end
        return c;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        logic [16:0] h, d;
        bit fire;
        if (!rst_n) begin
            exp_q.delete(); tag_q.delete();
            m_ack_p = 0; m_nak_p = 0;
        end else begin
            fire = (exp_q.size() > 0) && out_ready;
            if (fire) begin void'(exp_q.pop_front()); void'(tag_q.pop_front()); end
            if (exp_q.size() == 0) begin
                if (m_nak_p) begin
                    h = {1'b1, ESC, 4'h5, 3'b000, m_nak_creq};
                    exp_q.push_back(h); tag_q.push_back("R4");
                    exp_q.push_back({1'b0, crc_over(h, 17'd0, 1)}); tag_q.push_back("R5");
                    m_nak_p = 0;
                end else if (m_ack_p) begin
                    h = {1'b1, ESC, 4'h2, 2'b00, m_tc, m_ack_creq};
                    d = {1'b0, m_seq, 3'b000, m_cred};
                    exp_q.push_back(h); tag_q.push_back("R2");
                    exp_q.push_back(d); tag_q.push_back("R3");
                    exp_q.push_back({1'b0, crc_over(h, d, 2)}); tag_q.push_back("R5");
                    m_ack_p = 0;
                end
            end
            if (ack_req) begin
                m_ack_p = 1; m_seq = ack_seq; m_cred = ack_credit;
                m_tc = ack_tc[0]; m_ack_creq = ack_creq;
            end
            if (nak_req) begin m_nak_p = 1; m_nak_creq = nak_creq; end
        end
    end

    task automatic compare();
        bit ev = exp_q.size() > 0;
        vectors++;
        if (out_valid !== ev) begin
            errors++;
            $display("FAIL %s: out_valid actual %b expected %b", phase_tag, out_valid, ev);
        end else if (ev && out_sym !== exp_q[0]) begin
            errors++;
            $display("FAIL %s/%s: out_sym actual %h expected %h", tag_q[0], phase_tag, out_sym, exp_q[0]);
        end
    endtask

    task automatic step();
        @(negedge clk);
        compare();
        ack_req = 0; nak_req = 0;
    endtask

    task automatic send_ack(input logic [4:0] s, input logic [7:0] c, input logic t, input logic q);
        ack_req = 1; ack_seq = s; ack_credit = c; ack_tc = t; ack_creq = q;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: cycles actual %0d expected below 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state and quiet after release
        phase_tag = "R1";
        repeat (3) step();
        rst_n = 1;
        out_ready = 1;
        repeat (4) step();

        // R4/R5: lone nak, R2/R3/R5: lone ack
        phase_tag = "R4";
        nak_req = 1; nak_creq = 1;
        repeat (5) step();
        phase_tag = "R2";
        send_ack(5'd19, 8'hC3, 1'b1, 1'b0);
        repeat (6) step();

        // R6: both at once -> nak first
        phase_tag = "R6";
        send_ack(5'd7, 8'h11, 1'b0, 1'b1); nak_req = 1; nak_creq = 0;
        repeat (8) step();

        // R7/R9: stall mid-frame with a new request arriving
        phase_tag = "R9";
        out_ready = 0;
        send_ack(5'd30, 8'h80, 1'b1, 1'b1);
        step();
        phase_tag = "R7";
        repeat (3) step();
        nak_req = 1; nak_creq = 1;
        step();
        repeat (3) step();
        out_ready = 1;
        phase_tag = "R9";
        repeat (10) step();

        // R8: repeated acknowledge requests merge, newest fields win
        phase_tag = "R8";
        out_ready = 0;
        send_ack(5'd1, 8'h01, 1'b0, 1'b0); step();
        send_ack(5'd2, 8'h02, 1'b1, 1'b1); step();
        send_ack(5'd3, 8'h03, 1'b0, 1'b1); step();
        repeat (2) step();
        out_ready = 1;
        send_ack(5'd4, 8'h44, 1'b1, 1'b0); step();
        send_ack(5'd5, 8'h55, 1'b0, 1'b0); step();
        repeat (8) step();

        // Random traffic
        phase_tag = "R9";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            compare();
            out_ready  = ($urandom_range(0, 3) != 0);
            ack_req    = ($urandom_range(0, 4) == 0);
            ack_seq    = 5'($urandom);
            ack_credit = 8'($urandom);
            ack_tc     = 1'($urandom);
            ack_creq   = 1'($urandom);
            nak_req    = ($urandom_range(0, 6) == 0);
            nak_creq   = 1'($urandom);
        end
        ack_req = 0; nak_req = 0; out_ready = 1;
        repeat (10) step();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule